// File: doc/BRIEF.md
# Block-Transfer Raster Engine

This block copies a rectangular window of pixels inside a byte-addressed framebuffer memory. For every byte of the window it reads the source byte and the destination byte, merges them through a selectable 4-bit raster operation, and writes the result back to the destination. Software sets up the window size, the two start addresses and the two line increments through a small 32-bit register file, then writes a control word with the start bit set.

Scanning can run forward or in reverse along a line and down or up across lines, so overlapping moves can be ordered safely. A continuous-source mode treats the source as one packed run of bytes and ignores the source line increment. One further task may be queued behind the running one. An abort empties both the running slot and the queued slot.

Top module: `blit_engine`

## Requirements
- R1: The raster operation code sits in control bits [15:12] and acts as a truth table: each result bit equals code bit number (3 - 2*dst_bit - src_bit), so code 3 keeps the destination, 5 copies the source, 6 is XOR, C inverts the destination and F writes all ones.
- R2: A line spans width x (depth+1) bytes, with width in window bits [15:0], line count in window bits [31:16] and depth code in control bits [11:10] (0..3 for 1..4 bytes per pixel); each new line starts at the previous line start plus the destination increment (pitch bits [31:16]) for the destination and plus the source increment (pitch bits [15:0]) for the source.
- R3: Control bit 5 set makes addresses step down by one byte along a line instead of up; control bit 6 set makes both line increments subtract instead of add.
- R4: With control bit 7 set, the source address keeps stepping by one byte in the line direction across line ends and the source increment has no effect.
- R5: Writing control bit 31 (with bit 30 clear) while idle with no queued task makes status bit 31 (busy) read 1 from the next cycle; a window of width 0 or height 0 makes no memory access and finishes.
- R6: A start written while busy with the queue empty is queued and status bit 30 (queue full) reads 1; a start written while the queue is full is dropped.
- R7: When the running task finishes with a task queued, the queued task begins at once: queue full reads 0 while busy stays 1, and the tasks take effect in start order.
- R8: Writing control bit 30 empties the running and queued slots: busy and full read 0 from the next cycle and no memory request is made afterwards; a write with both bit 30 and bit 31 set starts nothing.
- R9: Register word index 0 is write-only control and reads back as status (bit 31 busy, bit 30 full, others 0); indices 1, 2, 3, 4 hold window, source address, destination address and pitch and read back as written.
- R10: Each byte is handled as source read, destination read, destination write; a request holds its address and direction until acknowledged, and no request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_IDX_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | LANE_W | Memory write data |
| mem_rdata | input | LANE_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge for the current request |

## Verification
Two pairs of events can share a cycle: a start written in the same cycle the running task finishes, and an abort written while a memory request is waiting for its acknowledge. The bench queues a short task behind a long one under randomly stalled acknowledges so that promotion lands on varying cycles, and it judges the result by polling the status every cycle (full must drop while busy stays high) and by comparing the whole memory against a model that applies the accepted tasks in order. Aborts are written mid-task under stalls, after which status must read zero at once and the count of memory writes must not move.

// File: rtl/blit_pkg.sv
package blit_pkg;

   // control word bit positions
   localparam int CTL_START  = 31;
   localparam int CTL_ABORT  = 30;
   localparam int CTL_ROP_LO = 12;
   localparam int CTL_BPP_LO = 10;
   localparam int CTL_SCONT  = 7;
   localparam int CTL_VDIR   = 6;
   localparam int CTL_HDIR   = 5;

   typedef struct packed {
      logic [3:0]  rop;
      logic [1:0]  bpp;
      logic        scont;
      logic        vdir;
      logic        hdir;
      logic [15:0] width;
      logic [15:0] height;
      logic [31:0] src;
      logic [31:0] dst;
      logic [15:0] spitch;
      logic [15:0] dpitch;
   } blit_task_t;

   typedef enum logic [2:0] {
      W_IDLE, W_RSRC, W_RDST, W_WDST, W_FIN
   } walk_st_t;

   function automatic logic [17:0] line_bytes(input logic [15:0] w, input logic [1:0] bpp);
      case (bpp)
         2'd0:    return {2'b00, w};
         2'd1:    return {1'b0, w, 1'b0};
         2'd2:    return {1'b0, w, 1'b0} + {2'b00, w};
         default: return {w, 2'b00};
      endcase
   endfunction

endpackage

// File: rtl/blit_rop.sv
module blit_rop #(
   parameter int LANE_W = 8
) (
   input  logic [3:0]        code,
   input  logic [LANE_W-1:0] s,
   input  logic [LANE_W-1:0] d,
   output logic [LANE_W-1:0] y
);
   for (genvar i = 0; i < LANE_W; i++) begin : g_bit
      assign y[i] = code[{~d[i], ~s[i]}];
   end
endmodule

// File: rtl/blit_regs.sv
module blit_regs
   import blit_pkg::*;
#(
   parameter int REG_IDX_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_IDX_W-1:0] addr,
   input  logic [31:0]          wdata,
   input  logic                 busy,
   input  logic                 full,
   output logic [31:0]          rdata,
   output logic                 start,
   output logic                 abort,
   output blit_task_t           new_task
);
   localparam logic [REG_IDX_W-1:0] IX_CTL = REG_IDX_W'(0);
   localparam logic [REG_IDX_W-1:0] IX_WIN = REG_IDX_W'(1);
   localparam logic [REG_IDX_W-1:0] IX_SRC = REG_IDX_W'(2);
   localparam logic [REG_IDX_W-1:0] IX_DST = REG_IDX_W'(3);
   localparam logic [REG_IDX_W-1:0] IX_PIT = REG_IDX_W'(4);

   logic [31:0] win_q, src_q, dst_q, pit_q;
   logic        ctl_wr;

   assign ctl_wr = wr_en && (addr == IX_CTL);
   assign abort  = ctl_wr && wdata[CTL_ABORT];
   assign start  = ctl_wr && wdata[CTL_START] && !wdata[CTL_ABORT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
         src_q <= '0;
         dst_q <= '0;
         pit_q <= '0;
      end else if (wr_en) begin
         case (addr)
            IX_WIN:  win_q <= wdata;
            IX_SRC:  src_q <= wdata;
            IX_DST:  dst_q <= wdata;
            IX_PIT:  pit_q <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      new_task        = '0;
      new_task.rop    = wdata[CTL_ROP_LO +: 4];
      new_task.bpp    = wdata[CTL_BPP_LO +: 2];
      new_task.scont  = wdata[CTL_SCONT];
      new_task.vdir   = wdata[CTL_VDIR];
      new_task.hdir   = wdata[CTL_HDIR];
      new_task.width  = win_q[15:0];
      new_task.height = win_q[31:16];
      new_task.src    = src_q;
      new_task.dst    = dst_q;
      new_task.spitch = pit_q[15:0];
      new_task.dpitch = pit_q[31:16];
   end

   always_comb begin
      case (addr)
         IX_CTL:  rdata = {busy, full, 30'b0};
         IX_WIN:  rdata = win_q;
         IX_SRC:  rdata = src_q;
         IX_DST:  rdata = dst_q;
         IX_PIT:  rdata = pit_q;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/blit_taskq.sv
module blit_taskq
   import blit_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       abort,
   input  blit_task_t new_task,
   input  logic       active,
   input  logic       done,
   output logic       load,
   output blit_task_t load_task,
   output logic       full
);
   logic       pend_v;
   blit_task_t pend_t;
   logic       slot_free;

   assign slot_free = !active || done;
   assign full      = pend_v;

   always_comb begin
      load      = 1'b0;
      load_task = new_task;
      if (!abort && slot_free) begin
         if (pend_v) begin
            load      = 1'b1;
            load_task = pend_t;
         end else if (start) begin
            load      = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v <= 1'b0;
         pend_t <= '0;
      end else if (abort) begin
         pend_v <= 1'b0;
      end else if (slot_free && pend_v) begin
         pend_v <= start;
         if (start) pend_t <= new_task;
      end else if (!slot_free && !pend_v && start) begin
         pend_v <= 1'b1;
         pend_t <= new_task;
      end
   end
endmodule

// File: rtl/blit_walker.sv
module blit_walker
   import blit_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  blit_task_t        load_task,
   input  logic              abort,
   input  logic              mem_ack,
   input  logic [LANE_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANE_W-1:0] mem_wdata,
   output logic              active,
   output logic              done
);
   walk_st_t          st;
   blit_task_t        t;
   logic [ADDR_W-1:0] scur, dcur, sline, dline;
   logic [ADDR_W-1:0] hstep, snext, dnext, spv, dpv;
   logic [17:0]       bpl, col;
   logic [15:0]       row;
   logic [LANE_W-1:0] sbyte, dbyte;
   logic              last_col, last_row, wr_ack;
   logic [63:0]       unused_addr_bits;

   assign unused_addr_bits = {t.src, t.dst};

   assign hstep    = t.hdir ? {ADDR_W{1'b1}} : ADDR_W'(1);
   assign spv      = ADDR_W'(t.spitch);
   assign dpv      = ADDR_W'(t.dpitch);
   assign snext    = t.vdir ? sline - spv : sline + spv;
   assign dnext    = t.vdir ? dline - dpv : dline + dpv;
   assign last_col = (col == bpl - 18'd1);
   assign last_row = (row == t.height - 16'd1);
   assign wr_ack   = (st == W_WDST) && mem_ack;
   assign done     = (wr_ack && last_col && last_row) || (st == W_FIN);
   assign active   = (st != W_IDLE);

   assign mem_req  = (st == W_RSRC) || (st == W_RDST) || (st == W_WDST);
   assign mem_we   = (st == W_WDST);
   assign mem_addr = (st == W_RSRC) ? scur : dcur;

   blit_rop #(.LANE_W(LANE_W)) u_rop (
      .code (t.rop),
      .s    (sbyte),
      .d    (dbyte),
      .y    (mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= W_IDLE;
         t     <= '0;
         scur  <= '0;
         dcur  <= '0;
         sline <= '0;
         dline <= '0;
         bpl   <= '0;
         col   <= '0;
         row   <= '0;
         sbyte <= '0;
         dbyte <= '0;
      end else if (abort) begin
         st <= W_IDLE;
      end else if (load) begin
         t     <= load_task;
         bpl   <= line_bytes(load_task.width, load_task.bpp);
         col   <= '0;
         row   <= '0;
         scur  <= load_task.src[ADDR_W-1:0];
         sline <= load_task.src[ADDR_W-1:0];
         dcur  <= load_task.dst[ADDR_W-1:0];
         dline <= load_task.dst[ADDR_W-1:0];
         st    <= (load_task.width == '0 || load_task.height == '0) ? W_FIN : W_RSRC;
      end else begin
         case (st)
            W_RSRC: if (mem_ack) begin
               sbyte <= mem_rdata;
               st    <= W_RDST;
            end
            W_RDST: if (mem_ack) begin
               dbyte <= mem_rdata;
               st    <= W_WDST;
            end
            W_WDST: if (mem_ack) begin
               if (last_col) begin
                  col   <= '0;
                  row   <= row + 16'd1;
                  dline <= dnext;
                  dcur  <= dnext;
                  if (t.scont) begin
                     scur <= scur + hstep;
                  end else begin
                     sline <= snext;
                     scur  <= snext;
                  end
                  st <= last_row ? W_IDLE : W_RSRC;
               end else begin
                  col  <= col + 18'd1;
                  scur <= scur + hstep;
                  dcur <= dcur + hstep;
                  st   <= W_RSRC;
               end
            end
            W_FIN:   st <= W_IDLE;
            default: st <= W_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/blit_engine.sv
module blit_engine
   import blit_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int LANE_W    = 8,
   parameter int REG_IDX_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [REG_IDX_W-1:0] reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [LANE_W-1:0]    mem_wdata,
   input  logic [LANE_W-1:0]    mem_rdata,
   input  logic                 mem_ack
);
   initial begin
      assert (ADDR_W >= 16 && ADDR_W <= 32) else $error("ADDR_W must lie in 16..32");
      assert (LANE_W == 8) else $error("LANE_W must be one byte");
      assert (REG_IDX_W >= 3) else $error("REG_IDX_W must cover five registers");
   end

   logic       start_w, abort_w, busy_w, full_w, load_w, done_w;
   blit_task_t new_task_w, load_task_w;

   blit_regs #(.REG_IDX_W(REG_IDX_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .busy     (busy_w),
      .full     (full_w),
      .rdata    (reg_rdata),
      .start    (start_w),
      .abort    (abort_w),
      .new_task (new_task_w)
   );

   blit_taskq u_taskq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_w),
      .abort     (abort_w),
      .new_task  (new_task_w),
      .active    (busy_w),
      .done      (done_w),
      .load      (load_w),
      .load_task (load_task_w),
      .full      (full_w)
   );

   blit_walker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_w),
      .load_task (load_task_w),
      .abort     (abort_w),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .active    (busy_w),
      .done      (done_w)
   );
endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk #(
   parameter int ADDR_W    = 16,
   parameter int REG_IDX_W = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_we,
   input logic [REG_IDX_W-1:0] reg_addr,
   input logic [31:0]          reg_wdata,
   input logic                 mem_req,
   input logic                 mem_we,
   input logic                 mem_ack,
   input logic [ADDR_W-1:0]    mem_addr,
   input logic                 busy,
   input logic                 full
);
   logic ctl_wr, abort_wr, start_wr;
   assign ctl_wr   = reg_we && (reg_addr == '0);
   assign abort_wr = ctl_wr && reg_wdata[30];
   assign start_wr = ctl_wr && reg_wdata[31] && !reg_wdata[30];

   p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr && !busy && !full) |=> busy);

   p_full_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> busy);

   p_abort_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_wr |=> (!busy && !full));

   p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_wr |=> !mem_req);

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !abort_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);
endmodule

bind blit_engine blit_engine_chk #(.ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr),
   .busy      (busy_w),
   .full      (full_w)
);

// File: tb/blit_engine_bench.sv
module blit_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we, mem_ack;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        ack_gate = 1'b1;

   int checks = 0;
   int fails = 0;
   int wr_count = 0;
   logic [7:0] mem    [0:1023];
   logic [7:0] shadow [0:1023];

   always #10 clk = ~clk;

   blit_engine u_blit_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   assign mem_ack   = mem_req && ack_gate;
   assign mem_rdata = mem[mem_addr[9:0]];

   always @(negedge clk) ack_gate <= ($urandom % 4) != 0;

   always @(posedge clk) begin
      if (mem_req && mem_we && mem_ack) begin
         mem[mem_addr[9:0]] <= mem_wdata;
         wr_count <= wr_count + 1;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] rop_ref(input logic [3:0] code, input logic [7:0] s, input logic [7:0] d);
      logic [7:0] y;
      for (int i = 0; i < 8; i++) y[i] = code[3 - 2*int'(d[i]) - int'(s[i])];
      return y;
   endfunction

   task automatic model(input int rop, bpp, hd, vd, sc, w, h, src, dst, sp, dp);
      int nb = w * (bpp + 1);
      int hs = hd ? -1 : 1;
      int vs = vd ? -1 : 1;
      for (int r = 0; r < h; r++) begin
         for (int c = 0; c < nb; c++) begin
            int da = dst + vs*r*dp + hs*c;
            int sa = sc ? src + hs*(r*nb + c) : src + vs*r*sp + hs*c;
            shadow[da & 1023] = rop_ref(4'(rop), shadow[sa & 1023], shadow[da & 1023]);
         end
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic launch(input int rop, bpp, hd, vd, sc, w, h, src, dst, sp, dp);
      reg_write(3'd1, {16'(h), 16'(w)});
      reg_write(3'd2, 32'(src));
      reg_write(3'd3, 32'(dst));
      reg_write(3'd4, {16'(dp), 16'(sp)});
      reg_write(3'd0, {1'b1, 1'b0, 14'b0, 4'(rop), 2'(bpp), 2'b0, 1'(sc), 1'(vd), 1'(hd), 5'b0});
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] st;
      int guard = 0;
      do begin
         @(negedge clk);
         reg_read(3'd0, st);
         guard++;
      end while (st != 0 && guard < 5000);
      if (guard >= 5000) check(1'b0, {tag, " idle timeout"}, st, 0);
   endtask

   task automatic compare_mem(input string tag);
      int bad = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] !== shadow[i]) bad++;
      check(bad == 0, tag, 32'(bad), 0);
   endtask

   task automatic sync_shadow();
      for (int i = 0; i < 1024; i++) shadow[i] = mem[i];
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] st;
      int wc;
      void'($urandom(32'd4242));
      for (int i = 0; i < 1024; i++) begin
         mem[i] = 8'($urandom);
         shadow[i] = mem[i];
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R9, R10)
      reg_read(3'd0, st);
      check(st == 0, "R9 status after reset", st, 0);
      check(mem_req == 1'b0, "R10 no request after reset", 32'(mem_req), 0);

      // register readback and status at offset 0 (R9)
      reg_write(3'd1, 32'h0003_0002);
      reg_read(3'd1, st);
      check(st == 32'h0003_0002, "R9 window readback", st, 32'h0003_0002);
      reg_write(3'd4, 32'h0011_0022);
      reg_read(3'd4, st);
      check(st == 32'h0011_0022, "R9 pitch readback", st, 32'h0011_0022);
      reg_write(3'd0, 32'h0000_F0E0);
      reg_read(3'd0, st);
      check(st == 0, "R9 control reads as status", st, 0);

      // every raster code on one line (R1)
      for (int code = 0; code < 16; code++) begin
         launch(code, 0, 0, 0, 0, 4, 1, 300, 700, 16, 16);
         model(code, 0, 0, 0, 0, 4, 1, 300, 700, 16, 16);
         wait_idle("R1");
         compare_mem($sformatf("R1 code %0d", code));
      end

      // 24-bit pixels with distinct pitches (R2)
      launch(5, 2, 0, 0, 0, 3, 3, 300, 700, 17, 21);
      model(5, 2, 0, 0, 0, 3, 3, 300, 700, 17, 21);
      reg_read(3'd0, st);
      check(st[31] == 1'b1, "R5 busy after start", st, 32'h8000_0000);
      wait_idle("R2");
      compare_mem("R2 24bpp window");

      // reverse scan on both axes (R3)
      launch(6, 1, 1, 1, 0, 3, 3, 400, 800, 18, 20);
      model(6, 1, 1, 1, 0, 3, 3, 400, 800, 18, 20);
      wait_idle("R3");
      compare_mem("R3 reverse scan");

      // continuous source, huge source pitch ignored (R4)
      launch(5, 0, 0, 0, 1, 5, 4, 200, 600, 300, 16);
      model(5, 0, 0, 0, 1, 5, 4, 200, 600, 300, 16);
      wait_idle("R4");
      compare_mem("R4 continuous source");

      // zero-size window (R5)
      wc = wr_count;
      launch(15, 0, 0, 0, 0, 0, 3, 300, 700, 16, 16);
      wait_idle("R5");
      check(wr_count == wc, "R5 zero width no writes", 32'(wr_count), 32'(wc));
      compare_mem("R5 zero width memory");

      // random tasks (R1 R2 R3 R4)
      for (int n = 0; n < 10; n++) begin
         int rop = $urandom_range(0, 15);
         int bpp = $urandom_range(0, 3);
         int hd = $urandom_range(0, 1);
         int vd = $urandom_range(0, 1);
         int sc = $urandom_range(0, 1);
         int w = $urandom_range(1, 4);
         int h = $urandom_range(1, 4);
         int sp = $urandom_range(16, 23);
         int dp = $urandom_range(16, 23);
         launch(rop, bpp, hd, vd, sc, w, h, 300, 700, sp, dp);
         model(rop, bpp, hd, vd, sc, w, h, 300, 700, sp, dp);
         wait_idle("R2 random");
         compare_mem($sformatf("R1 R2 R3 R4 random %0d", n));
      end

      // queue: second start waits, third dropped, promotion (R6 R7)
      launch(5, 3, 0, 0, 0, 4, 4, 300, 700, 16, 16);
      launch(6, 0, 0, 0, 0, 2, 2, 100, 900, 16, 16);
      reg_read(3'd0, st);
      check(st == 32'hC000_0000, "R6 queued start sets full", st, 32'hC000_0000);
      launch(15, 0, 0, 0, 0, 4, 2, 100, 950, 16, 16);
      reg_read(3'd0, st);
      check(st == 32'hC000_0000, "R6 start while full dropped", st, 32'hC000_0000);
      model(5, 3, 0, 0, 0, 4, 4, 300, 700, 16, 16);
      model(6, 0, 0, 0, 0, 2, 2, 100, 900, 16, 16);
      begin
         int guard = 0;
         do begin
            @(negedge clk);
            reg_read(3'd0, st);
            guard++;
         end while (st[30] && guard < 5000);
         check(st == 32'h8000_0000, "R7 full clears while busy stays", st, 32'h8000_0000);
      end
      wait_idle("R7");
      compare_mem("R6 R7 ordered queue result");

      // abort with a queued task (R8)
      launch(15, 3, 0, 0, 0, 4, 4, 300, 700, 16, 16);
      launch(12, 0, 0, 0, 0, 4, 4, 300, 900, 16, 16);
      repeat (30) @(negedge clk);
      reg_write(3'd0, 32'h4000_0000);
      reg_read(3'd0, st);
      check(st == 0, "R8 abort clears busy and full", st, 0);
      wc = wr_count;
      repeat (20) @(negedge clk);
      check(wr_count == wc, "R8 no writes after abort", 32'(wr_count), 32'(wc));
      check(mem_req == 1'b0, "R8 no request after abort", 32'(mem_req), 0);
      sync_shadow();

      // abort and start in one write (R8)
      reg_write(3'd0, 32'hC000_F000);
      reg_read(3'd0, st);
      check(st == 0, "R8 abort beats start", st, 0);
      repeat (10) @(negedge clk);
      compare_mem("R8 abort with start leaves memory");

      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule